// File: doc/BRIEF.md
# Serial Clock Prescaler

This block makes the serial bus clock for a two-wire bus controller from a fast system clock. Two programmable counters are chained: a 2-bit first-stage count and a 6-bit second-stage count. Together they make a prescaled tick every (A+1)×(B+1) input cycles. A fixed 22-step phase sequencer consumes these ticks. It holds the serial clock low for 11 ticks and then high for 11 ticks. It also emits a single-cycle strobe where outgoing data should change and another where incoming data should be sampled.

The divider fields come from a 16-bit control word. The control word is only copied into internal shadow registers while the bus controller reports the bus idle, so a divider change never disturbs a transfer in progress. When a different divider value is taken in, all counters restart, and the serial clock begins a fresh low phase. With the enable input low, the serial clock rests high, no strobes appear and the counters stay cleared.

Top module: `scl_prescaler`

## Requirements
- R1: The serial clock period is exactly 22×(A+1)×(B+1) input clock cycles. With A=0 and B=0 it is 22 cycles, which is the fastest possible rate.
- R2: A is taken from control word bits 15:14 and B from bits 13:8. Changes to bits 7:0 never alter the waveform and never cause a restart.
- R3: Within each period the serial clock is low for 11×(A+1)×(B+1) cycles first and then high for the same number of cycles.
- R4: The drive strobe is high for exactly one cycle per period. It falls 6×(A+1)×(B+1)−1 cycles after the cycle in which the serial clock went low, inside the low phase.
- R5: The sample strobe is high for exactly one cycle per period. It falls 17×(A+1)×(B+1)−1 cycles after the serial clock went low, inside the high phase.
- R6: While busIdle is low, changes to the divider fields have no effect on the running waveform.
- R7: A clock edge at which busIdle is high and the fields differ from the held values loads the new values and restarts the counters. In the next cycle the serial clock is low, and it rises 11×(A+1)×(B+1) cycles later using the new values.
- R8: Holding busIdle high while the divider fields are unchanged causes no restart, and the period stays as in R1.
- R9: While enable is low, sclOut is high and neither strobe fires. In the first cycle with enable high, sclOut is low and a new period starts.
- R10: After reset the held dividers are A=0 and B=0. During reset with enable low, sclOut is high and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the prescaler when high |
| busIdle | input | 1 | High while no transfer is in progress; permits divider update |
| ctrlWord | input | 16 | Control word; A in bits 15:14, B in bits 13:8 |
| sclOut | output | 1 | Serial clock level |
| driveTick | output | 1 | One-cycle strobe at the middle of the low phase |
| sampleTick | output | 1 | One-cycle strobe at the middle of the high phase |

## Verification
The assertions assume that enable, busIdle and ctrlWord are synchronous to clk. They also assume that the bus controller raises busIdle only when a restart of the serial clock is acceptable. The restart property relies on an independent record of the last value accepted while idle. The stimulus changes inputs only on the falling clock edge. Randomly drawn fields are confined to legal ranges by the bit slicing. B is kept small in random runs so that each measured period stays short, and the largest values are covered by a directed case.

// File: rtl/scl_prescaler_pkg.sv
package scl_prescaler_pkg;

  // Control decisions handed to the counter datapath each cycle
  typedef struct packed {
    logic clear;      // zero every counter
    logic stepB;      // first stage wrapped, advance second stage
    logic stepPhase;  // both stages wrapped, advance the phase sequencer
  } prescStrobes_t;

  // End-of-count flags reported back by the datapath
  typedef struct packed {
    logic endA;
    logic endB;
  } prescStatus_t;

endpackage

// File: rtl/scl_presc_datapath.sv
module scl_presc_datapath
  import scl_prescaler_pkg::*;
#(
  parameter int A_W        = 2,
  parameter int B_W        = 6,
  parameter int HALF_TICKS = 11,
  parameter int PHASE_W    = $clog2(2 * HALF_TICKS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [A_W-1:0]     divA,
  input  logic [B_W-1:0]     divB,
  input  prescStrobes_t      strobes,
  output prescStatus_t       status,
  output logic [PHASE_W-1:0] phase
);

  localparam int PERIOD = 2 * HALF_TICKS;
  localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(PERIOD - 1);

  logic [A_W-1:0] cntA;
  logic [B_W-1:0] cntB;

  assign status.endA = (cntA == divA);
  assign status.endB = (cntB == divB);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntA  <= '0;
      cntB  <= '0;
      phase <= '0;
    end else if (strobes.clear) begin
      cntA  <= '0;
      cntB  <= '0;
      phase <= '0;
    end else if (strobes.stepPhase) begin
      cntA  <= '0;
      cntB  <= '0;
      phase <= (phase == LAST_PHASE) ? '0 : phase + 1'b1;
    end else if (strobes.stepB) begin
      cntA <= '0;
      cntB <= cntB + 1'b1;
    end else begin
      cntA <= cntA + 1'b1;
    end
  end

endmodule

// File: rtl/scl_presc_ctrl.sv
module scl_presc_ctrl
  import scl_prescaler_pkg::*;
#(
  parameter int CTRL_W     = 16,
  parameter int A_W        = 2,
  parameter int B_W        = 6,
  parameter int A_LSB      = 14,
  parameter int B_LSB      = 8,
  parameter int HALF_TICKS = 11,
  parameter int PHASE_W    = $clog2(2 * HALF_TICKS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               busIdle,
  input  logic [CTRL_W-1:0]  ctrlWord,
  input  prescStatus_t       status,
  input  logic [PHASE_W-1:0] phase,
  output logic [A_W-1:0]     divA,
  output logic [B_W-1:0]     divB,
  output prescStrobes_t      strobes,
  output logic               sclOut,
  output logic               driveTick,
  output logic               sampleTick
);

  localparam logic [PHASE_W-1:0] HIGH_START = PHASE_W'(HALF_TICKS);
  localparam logic [PHASE_W-1:0] DRIVE_POS  = PHASE_W'(HALF_TICKS / 2);
  localparam logic [PHASE_W-1:0] SAMPLE_POS = PHASE_W'(HALF_TICKS + HALF_TICKS / 2);

  logic [A_W-1:0] fieldA;
  logic [B_W-1:0] fieldB;
  logic           loadNow;

  assign fieldA  = ctrlWord[A_LSB +: A_W];
  assign fieldB  = ctrlWord[B_LSB +: B_W];
  assign loadNow = busIdle && ((fieldA != divA) || (fieldB != divB));

  // Shadow copies of the divider fields, refreshed only while idle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divA <= '0;
      divB <= '0;
    end else if (loadNow) begin
      divA <= fieldA;
      divB <= fieldB;
    end
  end

  always_comb begin
    strobes.clear     = !enable || loadNow;
    strobes.stepB     = !strobes.clear && status.endA;
    strobes.stepPhase = strobes.stepB && status.endB;
  end

  assign sclOut     = enable ? (phase >= HIGH_START) : 1'b1;
  assign driveTick  = strobes.stepPhase && (phase == DRIVE_POS);
  assign sampleTick = strobes.stepPhase && (phase == SAMPLE_POS);

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler
  import scl_prescaler_pkg::*;
#(
  parameter int CTRL_W     = 16,
  parameter int A_W        = 2,
  parameter int B_W        = 6,
  parameter int A_LSB      = 14,
  parameter int B_LSB      = 8,
  parameter int HALF_TICKS = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              busIdle,
  input  logic [CTRL_W-1:0] ctrlWord,
  output logic              sclOut,
  output logic              driveTick,
  output logic              sampleTick
);

  localparam int PHASE_W = $clog2(2 * HALF_TICKS);

  logic [A_W-1:0]     divA;
  logic [B_W-1:0]     divB;
  logic [PHASE_W-1:0] phase;
  prescStrobes_t      strobes;
  prescStatus_t       status;

  scl_presc_ctrl #(
    .CTRL_W(CTRL_W), .A_W(A_W), .B_W(B_W), .A_LSB(A_LSB), .B_LSB(B_LSB),
    .HALF_TICKS(HALF_TICKS), .PHASE_W(PHASE_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .enable(enable), .busIdle(busIdle),
    .ctrlWord(ctrlWord), .status(status), .phase(phase),
    .divA(divA), .divB(divB), .strobes(strobes),
    .sclOut(sclOut), .driveTick(driveTick), .sampleTick(sampleTick)
  );

  scl_presc_datapath #(
    .A_W(A_W), .B_W(B_W), .HALF_TICKS(HALF_TICKS), .PHASE_W(PHASE_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .divA(divA), .divB(divB),
    .strobes(strobes), .status(status), .phase(phase)
  );

endmodule

// File: rtl/scl_prescaler_chk.sv
module scl_prescaler_chk #(
  parameter int CTRL_W = 16,
  parameter int A_W    = 2,
  parameter int B_W    = 6,
  parameter int A_LSB  = 14,
  parameter int B_LSB  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              busIdle,
  input logic [CTRL_W-1:0] ctrlWord,
  input logic              sclOut,
  input logic              driveTick,
  input logic              sampleTick
);

  logic [A_W+B_W-1:0] seenFields;
  logic [A_W+B_W-1:0] nowFields;
  logic               loadEvt;

  assign nowFields = {ctrlWord[A_LSB +: A_W], ctrlWord[B_LSB +: B_W]};
  assign loadEvt   = busIdle && (nowFields != seenFields);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        seenFields <= '0;
    else if (busIdle) seenFields <= nowFields;
  end

  // R4
  drv_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    driveTick |=> !driveTick);

  // R4
  drv_in_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    driveTick |-> !sclOut);

  // R5
  smp_in_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleTick |-> sclOut);

  // R9
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (sclOut && !driveTick && !sampleTick));

  // R7
  restart_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && loadEvt) |=> (!enable || !sclOut));

endmodule

bind scl_prescaler scl_prescaler_chk #(
  .CTRL_W(CTRL_W), .A_W(A_W), .B_W(B_W), .A_LSB(A_LSB), .B_LSB(B_LSB)
) chk_i (
  .clk(clk), .rstN(rstN), .enable(enable), .busIdle(busIdle),
  .ctrlWord(ctrlWord), .sclOut(sclOut), .driveTick(driveTick),
  .sampleTick(sampleTick)
);

// File: tb/scl_prescaler_tb.sv
module scl_prescaler_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        busIdle = 1'b0;
  logic [15:0] ctrlWord = 16'h0000;
  logic        sclOut, driveTick, sampleTick;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit lastScl = 1'b1, curScl = 1'b1, curDrv = 1'b0, curSmp = 1'b0;

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  scl_prescaler dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .busIdle(busIdle),
    .ctrlWord(ctrlWord), .sclOut(sclOut), .driveTick(driveTick),
    .sampleTick(sampleTick)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R2: A in bits 15:14, B in bits 13:8, low byte is noise
  function automatic logic [15:0] packCtrl(input int a, input int b, input logic [7:0] noise);
    return {a[1:0], b[5:0], noise};
  endfunction

  task automatic step();
    @(negedge clk);
    lastScl = curScl;
    curScl  = sclOut;
    curDrv  = driveTick;
    curSmp  = sampleTick;
  endtask

  task automatic setFields(input int a, input int b);
    ctrlWord = packCtrl(a, b, 8'($urandom));
    busIdle  = 1'b1;
    step();
    busIdle  = 1'b0;
  endtask

  // Measures one full period starting at a falling edge of the serial clock
  task automatic checkPeriod(input int a, input int b, input string tag);
    int m, p, n, eScl, eDrv, eSmp, firstAct, firstExp, nDrv, nSmp;
    bit found;
    m = (a + 1) * (b + 1);
    p = 22 * m;
    n = 0;
    found = 1'b0;
    while (!found && n < 2 * p + 50) begin
      step();
      n++;
      if (lastScl && !curScl) found = 1'b1;
    end
    check(found, tag, "serial clock falling edge seen", int'(found), 1);
    eScl = 0; eDrv = 0; eSmp = 0; nDrv = 0; nSmp = 0;
    firstAct = 0; firstExp = 0;
    for (int off = 0; off <= p; off++) begin
      int r;
      bit expS, expD, expM;
      if (off > 0) step();
      r = off % p;
      expS = (r >= 11 * m);
      expD = (r == 6 * m - 1);
      expM = (r == 17 * m - 1);
      if (off < p) begin
        nDrv += int'(curDrv);
        nSmp += int'(curSmp);
      end
      if (curScl != expS) begin
        if (eScl == 0) begin firstAct = off; firstExp = int'(expS); end
        eScl++;
      end
      if (curDrv != expD) eDrv++;
      if (curSmp != expM) eSmp++;
    end
    // R1 R3: waveform levels over the whole period
    check(eScl == 0, {tag, " R1 R3"}, $sformatf("scl mismatches a=%0d b=%0d (first at offset %0d, expected level %0d)",
          a, b, firstAct, firstExp), eScl, 0);
    // R4: drive strobe placement and count
    check(eDrv == 0 && nDrv == 1, {tag, " R4"}, $sformatf("drive strobe mismatches a=%0d b=%0d", a, b), eDrv, 0);
    // R5: sample strobe placement and count
    check(eSmp == 0 && nSmp == 1, {tag, " R5"}, $sformatf("sample strobe mismatches a=%0d b=%0d", a, b), eSmp, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (cyc > 190000 && !done) begin
        done = 1'b1;
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected below 190000", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int ra, rb, ka, kb;
    void'($urandom(32'd20240917));
    ctrlWord = packCtrl(2, 5, 8'hA5);

    // R10: reset state
    repeat (3) step();
    check(curScl == 1'b1, "R10", "scl during reset", int'(curScl), 1);
    check(!curDrv && !curSmp, "R10", "strobes during reset", int'(curDrv | curSmp), 0);
    rstN = 1'b1;
    step();

    // R9: first enabled cycle is low; R10 R6: held dividers are zero despite busy field change
    enable = 1'b1;
    #1;
    check(sclOut == 1'b0, "R9", "scl in first enabled cycle", int'(sclOut), 0);
    step();
    checkPeriod(0, 0, "R10 R6");

    // Directed extremes
    setFields(3, 63);
    checkPeriod(3, 63, "max");
    setFields(0, 0);
    checkPeriod(0, 0, "min");
    setFields(2, 0);
    checkPeriod(2, 0, "a-only");

    // Random configurations
    for (int i = 0; i < 6; i++) begin
      ra = int'($urandom_range(3, 0));
      rb = int'($urandom_range(15, 0));
      setFields(ra, rb);
      checkPeriod(ra, rb, "rand");
    end

    // R8 R2: idle held high, same fields, only noise bits move
    ka = 1; kb = 2;
    setFields(ka, kb);
    busIdle = 1'b1;
    ctrlWord = packCtrl(ka, kb, 8'h3C);
    checkPeriod(ka, kb, "R8 R2");
    ctrlWord = packCtrl(ka, kb, 8'hC3);
    checkPeriod(ka, kb, "R8 R2");
    busIdle = 1'b0;

    // R6: field change while busy is ignored
    ctrlWord = packCtrl(3, 9, 8'h00);
    checkPeriod(ka, kb, "R6");

    // R7: load during the high phase restarts with new values
    ctrlWord = packCtrl(ka, kb, 8'h00);
    while (!curScl) step();
    ctrlWord = packCtrl(0, 3, 8'h11);
    busIdle = 1'b1;
    step();
    busIdle = 1'b0;
    check(curScl == 1'b0, "R7", "scl right after restart", int'(curScl), 0);
    begin
      int off;
      off = 0;
      while (!curScl && off < 500) begin
        step();
        off++;
      end
      check(off == 44, "R7", "cycles from restart to rise", off, 44);
    end
    checkPeriod(0, 3, "R7");

    // R9: disabled behaviour
    enable = 1'b0;
    step();
    begin
      int bad;
      bad = 0;
      for (int k = 0; k < 200; k++) begin
        if (!curScl || curDrv || curSmp) bad++;
        step();
      end
      check(bad == 0, "R9", "cycles with scl low or a strobe while disabled", bad, 0);
    end
    enable = 1'b1;
    #1;
    check(sclOut == 1'b0, "R9", "scl on re-enable", int'(sclOut), 0);
    step();
    checkPeriod(0, 3, "R9");

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule